// File: doc/BRIEF.md
# Iterative Integer Divider with Illegal-Division Flag

This block divides one 32-bit integer by another over several clock cycles, in signed or unsigned mode. The caller presents a dividend, a divisor and a mode bit with a one-cycle start strobe while the unit is idle. The unit then stays busy for a number of cycles set by the sizes of the operands and raises a one-cycle done strobe. At that point the quotient and the overflow flag are valid. A division by zero and the one signed quotient that cannot be represented are not computed. They raise the overflow flag and leave the previous quotient in place.

The magnitude of each operand is measured by its bit-length, which is the 1-based position of its highest set bit (zero for a value of zero). The bit-length is folded into a bucket equal to ceil(bit-length / 2). The datapath retires two quotient bits per cycle, starting at the highest pair that can be nonzero. Small quotients therefore finish early. The controller has four states. IDLE goes to CHECK on an accepted start. CHECK goes to FINISH on an illegal division, or to RUN with a step count. RUN stays in RUN while steps remain and goes to FINISH after the last step. FINISH goes back to IDLE after one cycle.

Top module: `int_divider`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy, done and overflow are 0 and quotient is 0.
- R2: A start seen at a rising edge while busy is 0 is accepted. busy is 1 from the next cycle through the done cycle, and done is high for exactly one cycle.
- R3: A start seen while busy is 1 is ignored. It neither changes the operands in progress nor the timing or result of the running division.
- R4: In unsigned mode the quotient is floor(dividend / divisor), with both operands read as unsigned.
- R5: In signed mode the quotient is the two's-complement quotient rounded toward zero.
- R6: A divisor of zero sets overflow in either mode, and the quotient output keeps its previous value.
- R7: In signed mode, a dividend of 0x80000000 with a divisor of 0xFFFFFFFF sets overflow and keeps the quotient. In unsigned mode the same operands are a legal division that gives 0.
- R8: A legal division clears overflow when done is raised.
- R9: For a legal division, count the accepting edge as edge 0. done is high in the cycle after edge 2 + max(0, Ba - Bb), where Ba and Bb are the buckets of the dividend and divisor magnitudes.
- R10: In signed mode a negative operand is negated before its bit-length is taken, so 0x80000000 has bucket 16 and 0xFFFFFFFF has bucket 1.
- R11: For an illegal division, done is high in the cycle after edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, accepted only while idle |
| signed_mode | input | 1 | 1 = operands are two's complement |
| dividend | input | 32 | Numerator |
| divisor | input | 32 | Denominator |
| busy | output | 1 | Division in progress, including the done cycle |
| done | output | 1 | One-cycle completion strobe |
| overflow | output | 1 | Last division was illegal |
| quotient | output | 32 | Last legal quotient |

## Verification
The hardest cases to reach from the ports are the latency extremes, together with a start that arrives during a long division. The longest run is a bucket-16 dividend over a bucket-1 divisor. In signed mode that includes 0x80000000 divided by 1, where the negated value is still 0x80000000. The shortest run clamps when the divisor is larger than the dividend. The stimulus places these operands directly. It raises a second start two cycles into a long run and checks that both the result and the timing still match the first request. Randomized operands are then shifted right by random amounts, so the bucket differences cover the full range in both modes, with zero divisors mixed in.

// File: rtl/int_div_pkg.sv
package int_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_RUN    = 2'd2,
        ST_FINISH = 2'd3
    } div_state_e;

endpackage

// File: rtl/div_bucket.sv
module div_bucket #(
    parameter int WIDTH = 32,
    localparam int BW = $clog2(WIDTH / 2 + 1)
) (
    input  logic [WIDTH-1:0] mag,
    output logic [BW-1:0]    bucket
);

    int len;

    // bit-length = 1-based index of the highest set bit
    always_comb begin
        len = 0;
        for (int i = 0; i < WIDTH; i++) begin
            if (mag[i]) len = i + 1;
        end
        bucket = BW'((len + 1) / 2);
    end

endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
    import int_div_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int CW = $clog2(WIDTH / 2 + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          illegal,
    input  logic [CW-1:0] steps,
    output div_state_e    state,
    output logic          busy,
    output logic          done,
    output logic          accept,
    output logic          load_core,
    output logic          step_en,
    output logic          fin_valid,
    output logic          fin_illegal
);

    localparam logic [CW-1:0] MAX_STEPS = CW'(WIDTH / 2);
    localparam logic [CW-1:0] ONE       = CW'(1);

    div_state_e    state_nxt;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            state <= state_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt_q;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nxt = ST_CHECK;
            end
            ST_CHECK: begin
                if (illegal) begin
                    state_nxt = ST_FINISH;
                end else begin
                    state_nxt = ST_RUN;
                    cnt_nxt   = steps;
                end
            end
            ST_RUN: begin
                if (cnt_q == ONE) begin
                    state_nxt = ST_FINISH;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt_q - ONE;
                end
            end
            ST_FINISH: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy        = 1'b0;
        done        = 1'b0;
        accept      = 1'b0;
        load_core   = 1'b0;
        step_en     = 1'b0;
        fin_valid   = 1'b0;
        fin_illegal = 1'b0;
        unique case (state)
            ST_IDLE: begin
                accept = start;
            end
            ST_CHECK: begin
                busy        = 1'b1;
                load_core   = !illegal;
                fin_illegal = illegal;
            end
            ST_RUN: begin
                busy      = 1'b1;
                step_en   = 1'b1;
                fin_valid = (cnt_q == ONE);
            end
            ST_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
        endcase
    end

    // R9: the step counter stays inside the legal window while running
    p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (cnt_q != '0 && cnt_q <= MAX_STEPS));

    // R2: FINISH is always left after one cycle
    p_finish_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH) |=> (state == ST_IDLE));

endmodule

// File: rtl/div_core.sv
module div_core #(
    parameter int WIDTH = 32,
    localparam int CW = $clog2(WIDTH / 2 + 1),
    localparam int SW = $clog2(WIDTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             fin,
    input  logic [WIDTH-1:0] mag_a,
    input  logic [WIDTH-1:0] mag_b,
    input  logic [CW-1:0]    steps,
    input  logic             negate,
    output logic [WIDTH-1:0] quotient
);

    logic [WIDTH-1:0] rem_q, dsr_q, quo_q, div_q, res_q;
    logic             neg_q;
    logic [WIDTH-1:0] rem_nxt, dsr_nxt, quo_nxt;
    logic [SW-1:0]    pre_sh, post_sh;

    // skip the quotient bit pairs that are known to be zero
    assign pre_sh  = SW'({steps, 1'b0});
    assign post_sh = SW'(WIDTH) - pre_sh;

    // two restoring steps per cycle
    always_comb begin
        logic [WIDTH:0] trial;
        rem_nxt = rem_q;
        dsr_nxt = dsr_q;
        quo_nxt = quo_q;
        for (int k = 0; k < 2; k++) begin
            trial   = {rem_nxt, dsr_nxt[WIDTH-1]};
            dsr_nxt = {dsr_nxt[WIDTH-2:0], 1'b0};
            if (trial >= {1'b0, div_q}) begin
                trial   = trial - {1'b0, div_q};
                quo_nxt = {quo_nxt[WIDTH-2:0], 1'b1};
            end else begin
                quo_nxt = {quo_nxt[WIDTH-2:0], 1'b0};
            end
            rem_nxt = trial[WIDTH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            dsr_q <= '0;
            quo_q <= '0;
            div_q <= '0;
            neg_q <= 1'b0;
            res_q <= '0;
        end else begin
            if (load) begin
                rem_q <= mag_a >> pre_sh;
                dsr_q <= mag_a << post_sh;
                quo_q <= '0;
                div_q <= mag_b;
                neg_q <= negate;
            end else if (step) begin
                rem_q <= rem_nxt;
                dsr_q <= dsr_nxt;
                quo_q <= quo_nxt;
            end
            if (fin) res_q <= neg_q ? (~quo_nxt + 1'b1) : quo_nxt;
        end
    end

    assign quotient = res_q;

    // R4: the partial remainder is always below the divisor while stepping
    p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (rem_q < div_q));

endmodule

// File: rtl/int_divider.sv
module int_divider
    import int_div_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             signed_mode,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic             overflow,
    output logic [WIDTH-1:0] quotient
);

    localparam int CW = $clog2(WIDTH / 2 + 1);
    localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ALL_ONE = '1;

    logic [WIDTH-1:0] a_q, b_q;
    logic             sgn_q, ovf_q;
    logic [WIDTH-1:0] mag_a, mag_b;
    logic [CW-1:0]    bkt_a, bkt_b, diff, steps;
    logic             illegal, negate;
    div_state_e       state;
    logic             accept, load_core, step_en, fin_valid, fin_illegal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            sgn_q <= 1'b0;
        end else if (accept) begin
            a_q   <= dividend;
            b_q   <= divisor;
            sgn_q <= signed_mode;
        end
    end

    // magnitudes: negate negative operands in signed mode
    assign mag_a   = (sgn_q && a_q[WIDTH-1]) ? (~a_q + 1'b1) : a_q;
    assign mag_b   = (sgn_q && b_q[WIDTH-1]) ? (~b_q + 1'b1) : b_q;
    assign negate  = sgn_q && (a_q[WIDTH-1] ^ b_q[WIDTH-1]);
    assign illegal = (b_q == '0) || (sgn_q && a_q == MIN_NEG && b_q == ALL_ONE);

    div_bucket #(.WIDTH(WIDTH)) u_bkt_a (.mag(mag_a), .bucket(bkt_a));
    div_bucket #(.WIDTH(WIDTH)) u_bkt_b (.mag(mag_b), .bucket(bkt_b));

    assign diff  = (bkt_a > bkt_b) ? (bkt_a - bkt_b) : '0;
    assign steps = diff + CW'(1);

    div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .illegal     (illegal),
        .steps       (steps),
        .state       (state),
        .busy        (busy),
        .done        (done),
        .accept      (accept),
        .load_core   (load_core),
        .step_en     (step_en),
        .fin_valid   (fin_valid),
        .fin_illegal (fin_illegal)
    );

    div_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_core),
        .step     (step_en),
        .fin      (fin_valid),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .steps    (steps),
        .negate   (negate),
        .quotient (quotient)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           ovf_q <= 1'b0;
        else if (fin_illegal) ovf_q <= 1'b1;
        else if (fin_valid)   ovf_q <= 1'b0;
    end

    assign overflow = ovf_q;

    // R2: done is a single-cycle pulse and only while busy
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R3: operands in flight are untouched by a start during busy
    p_ignore_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(a_q) && $stable(b_q) && $stable(sgn_q)));

    // R6: an illegal division leaves the quotient alone
    p_hold_on_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overflow) |-> $stable(quotient));

    // R6: in unsigned mode only a zero divisor is illegal
    p_unsigned_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overflow && !sgn_q) |-> (b_q == '0));

    // R7: signed most-negative over minus one is flagged
    p_min_neg1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sgn_q && a_q == MIN_NEG && b_q == ALL_ONE) |-> overflow);

    // R8: a legal completion clears the flag
    p_valid_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fin_valid |=> !overflow);

endmodule

// File: tb/int_divider_tb.sv
module int_divider_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done, overflow;
    logic [31:0] quotient;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    int_divider u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .overflow(overflow), .quotient(quotient)
    );

    // ---------------- behavioural reference ----------------
    function automatic int bucket_of(input logic [31:0] v);
        int len = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) begin
                len = i + 1;
                break;
            end
        end
        return (len + 1) / 2;
    endfunction

    function automatic logic [31:0] magnitude(input logic [31:0] v, input bit sm);
        if (sm && v[31]) return -v;
        return v;
    endfunction

    function automatic bit is_illegal(input logic [31:0] a, input logic [31:0] b, input bit sm);
        return (b == 0) || (sm && a == 32'h8000_0000 && b == 32'hFFFF_FFFF);
    endfunction

    function automatic int latency_of(input logic [31:0] a, input logic [31:0] b, input bit sm);
        int d;
        if (is_illegal(a, b, sm)) return 1;
        d = bucket_of(magnitude(a, sm)) - bucket_of(magnitude(b, sm));
        return 2 + ((d > 0) ? d : 0);
    endfunction

    function automatic logic [31:0] quot_of(input logic [31:0] a, input logic [31:0] b, input bit sm);
        longint sa, sb, sq;
        if (sm) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
        end else begin
            sa = longint'({32'd0, a});
            sb = longint'({32'd0, b});
        end
        sq = sa / sb;
        return sq[31:0];
    endfunction

    bit          m_busy = 0, m_done = 0, m_ovf = 0, p_ovf = 0;
    logic [31:0] m_q = '0, p_q = '0;
    int          m_cnt = 0;
    string       m_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_ovf = 0; m_q = '0; m_cnt = 0;
        end else if (m_done) begin
            m_done = 0;
            m_busy = 0;
        end else if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_done = 1;
                m_ovf  = p_ovf;
                if (!p_ovf) m_q = p_q;
            end
        end else if (start) begin
            p_ovf  = is_illegal(dividend, divisor, signed_mode);
            p_q    = p_ovf ? '0 : quot_of(dividend, divisor, signed_mode);
            m_cnt  = latency_of(dividend, divisor, signed_mode);
            m_busy = 1;
            if (p_ovf)            m_tag = (divisor == 0) ? "R6" : "R7";
            else if (signed_mode) m_tag = "R5";
            else                  m_tag = "R4";
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2", "busy", 32'(busy), 32'(m_busy));
            check(p_ovf ? "R11" : "R9", "done", 32'(done), 32'(m_done));
            check(p_ovf ? m_tag : "R8", "overflow", 32'(overflow), 32'(m_ovf));
            check(m_tag, "quotient", quotient, m_q);
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_op(input logic [31:0] a, input logic [31:0] b, input bit sm,
                         input string req);
        int k = 0;
        while (busy) @(negedge clk);
        dividend = a; divisor = b; signed_mode = sm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) begin
            @(negedge clk);
            k++;
        end
        check(req, "latency", 32'(k), 32'(latency_of(a, b, sm)));
        if (!is_illegal(a, b, sm))
            check(req, "result", quotient, quot_of(a, b, sm));
        check(req, "flag", 32'(overflow), 32'(is_illegal(a, b, sm)));
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R1", "busy", 32'(busy), 0);
        check("R1", "done", 32'(done), 0);
        check("R1", "overflow", 32'(overflow), 0);
        check("R1", "quotient", quotient, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "quotient after release", quotient, 0);

        do_op(32'd100, 32'd7, 0, "R4");
        do_op(32'hFFFF_FFFF, 32'd1, 0, "R9");
        do_op(32'd5, 32'hFFFF_FFF0, 0, "R9");
        do_op(-32'sd7, 32'd2, 1, "R5");
        do_op(32'd7, -32'sd2, 1, "R5");
        do_op(-32'sd7, -32'sd2, 1, "R5");
        do_op(32'd1234, 32'd0, 1, "R6");
        do_op(32'd99, 32'd0, 0, "R6");
        do_op(32'd50, 32'd5, 1, "R8");
        do_op(32'h8000_0000, 32'hFFFF_FFFF, 1, "R7");
        do_op(32'h8000_0000, 32'hFFFF_FFFF, 0, "R7");
        do_op(32'h8000_0000, 32'd1, 1, "R10");
        do_op(32'd3, 32'hFFFF_FFFF, 1, "R10");
        do_op(32'd0, 32'd9, 1, "R9");

        // R3: second start two cycles into a long run
        while (busy) @(negedge clk);
        dividend = 32'hFFFF_FFFF; divisor = 32'd3; signed_mode = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        dividend = 32'd8; divisor = 32'd0; signed_mode = 1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check("R3", "result", quotient, 32'h5555_5555);
        check("R3", "flag", 32'(overflow), 0);
        @(negedge clk);

        for (int n = 0; n < 80; n++) begin
            logic [31:0] ra, rb;
            ra = $urandom >> ($urandom % 32);
            rb = ($urandom % 9 == 0) ? 32'd0 : ($urandom >> ($urandom % 32));
            do_op(ra, rb, bit'($urandom % 2), ($urandom % 2) ? "R4" : "R5");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule